// File: doc/BRIEF.md
# Converter Configuration and Status Register

This block is a single 24-bit register word that sets up a converter front end and reports its health. Software reaches it through a plain synchronous access port: a write strobe with 24 bits of write data, and a read strobe with 24 bits of read data. The writable control fields leave the block as separate outputs so that the rest of the chip can use them directly:

- chop rate code and its decoded clock divisor
- multi-setup, loop and read-wait modes
- depth pointer
- sleep/standby choice, charge-pump enable, power-save and low-power mode
- software reset

Three status flags sit beside the controls. They can only be read. Each one is set by an event and stays set until a read of the register clears it. Bits that carry no function always read as zero.

A software reset bit takes the block into a reset cycle, and the cycle lasts until software clears the bit. While the bit is set, the other control fields stay at zero and writes to them are ignored. The write that clears the bit marks a completed reset by setting the reset-done flag.

Top module: `adc_cfg_reg`

## Requirements
- R1: After the asynchronous reset, every stored field and flag is 0. So `rdata` reads 0x000000, `chop_div` is 128, `pump_oe` is 1, and every other control output is 0.
- R2: Bits 23, 22, 19 and 3..0 of `rdata` are always 0, whatever was written to them.
- R3: While the software reset bit is 0, a write stores the following fields, and each reads back at the same position:
  - chop code at bits 21..20
  - multi-setup at bit 18
  - loop at bit 17
  - read-wait at bit 16
  - depth pointer at bits 15..12
  - sleep select at bit 11
  - pump disable at bit 10
  - power-save at bit 9
  - low-power at bit 8
  
  Each field also drives its own output.
- R4: A write with bit 7 = 1 while the reset bit is 0 sets `sys_rst` to 1 and forces all other writable fields to 0 at the same clock edge.
- R5: While the reset bit is 1, write data on every bit except bit 7 is ignored. Only a write with bit 7 = 0 ends the reset cycle, and the other fields stay 0 after that write.
- R6: The reset-done flag at bit 6 is set at the edge where a write clears a set reset bit. Writes do not change it, and a read clears it at the following edge.
- R7: The oscillation flag at bit 5 sets when `osc_evt` is high at an edge. The overrange flag at bit 4 sets when `ovr_evt` is high at an edge. Both flags hold until a read clears them, and writes do not change them.
- R8: When a read and a flag's set event fall in the same cycle, the flag is set after that edge.
- R9: `chop_div` decodes the chop code as follows: 00 gives 128, 01 gives 8, 10 gives 2, 11 gives 32.
- R10: `pump_oe` is the inverse of the stored pump-disable bit.
- R11: `rdata` shows the current register contents in the same cycle. A read therefore returns the flag values from before the read clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; clears the status flags |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Register contents |
| osc_evt | input | 1 | Oscillation condition from the modulator |
| ovr_evt | input | 1 | Overrange condition from the input monitor |
| chop_sel | output | 2 | Stored chop code |
| chop_div | output | 8 | Decoded chop clock divisor |
| multi_setup | output | 1 | Multi-setup conversion mode |
| loop_en | output | 1 | Continuous conversion mode |
| read_wait | output | 1 | Wait for read before reconverting |
| depth_ptr | output | 4 | Depth pointer |
| sleep_sel | output | 1 | 1 = sleep, 0 = standby when power-saving |
| pump_oe | output | 1 | Charge-pump output enable |
| pwr_save | output | 1 | Power-save request |
| low_pwr | output | 1 | Reduced power mode |
| sys_rst | output | 1 | Software reset active |

## Verification
The hardest states to reach from the ports are the ones where two things meet on the same edge:
- a read and a flag event
- a write that clears the reset bit while carrying nonzero data in the other fields

Random stimulus with a fixed seed mixes reads, writes and events every cycle. About one write in eight sets bit 7, so the reset cycle is entered and left many times with random data on the other bits. Directed steps add the other cases one at a time: a read together with an event, writes aimed at the flag bits and the reserved bits, and each of the four chop codes.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;
  localparam int REG_W   = 24;
  localparam int DEPTH_W = 4;
  localparam int CHOP_W  = 2;
  localparam int N_FLAGS = 3;

  // bit positions
  localparam int B_CHOP  = 20;
  localparam int B_MULTI = 18;
  localparam int B_LOOP  = 17;
  localparam int B_RDW   = 16;
  localparam int B_DEPTH = 12;
  localparam int B_SLEEP = 11;
  localparam int B_PUMP  = 10;
  localparam int B_PSAVE = 9;
  localparam int B_LOWP  = 8;
  localparam int B_SRST  = 7;
  localparam int B_FLAG  = 4;   // flags at 6:4 = {done, osc, ovr}

  localparam logic [REG_W-1:0] RSVD_MASK = 24'hC8000F;

  typedef struct packed {
    logic [CHOP_W-1:0]  chop;
    logic               multi;
    logic               loop;
    logic               rdwait;
    logic [DEPTH_W-1:0] depth;
    logic               sleep;
    logic               pump_dis;
    logic               psave;
    logic               lowp;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.chop     = w[B_CHOP +: CHOP_W];
    c.multi    = w[B_MULTI];
    c.loop     = w[B_LOOP];
    c.rdwait   = w[B_RDW];
    c.depth    = w[B_DEPTH +: DEPTH_W];
    c.sleep    = w[B_SLEEP];
    c.pump_dis = w[B_PUMP];
    c.psave    = w[B_PSAVE];
    c.lowp     = w[B_LOWP];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_CHOP +: CHOP_W]   = c.chop;
    w[B_MULTI]            = c.multi;
    w[B_LOOP]             = c.loop;
    w[B_RDW]              = c.rdwait;
    w[B_DEPTH +: DEPTH_W] = c.depth;
    w[B_SLEEP]            = c.sleep;
    w[B_PUMP]             = c.pump_dis;
    w[B_PSAVE]            = c.psave;
    w[B_LOWP]             = c.lowp;
    return w;
  endfunction
endpackage

// File: rtl/adc_cfg_ctrl.sv
module adc_cfg_ctrl
  import adc_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl_q,
  output logic             srst_q,
  output logic             srst_done
);
  ctrl_t ctrl_d;
  logic  srst_d;
  logic  ctrl_en;

  always_comb begin
    ctrl_en   = wr_en;
    srst_d    = wdata[B_SRST];
    srst_done = wr_en && srst_q && !wdata[B_SRST];
    if (srst_q || wdata[B_SRST]) ctrl_d = '0;
    else                         ctrl_d = unpack_ctrl(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      srst_q <= 1'b0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
      srst_q <= srst_d;
    end
  end

  // R4
  srst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !srst_q && wdata[B_SRST]) |=> (srst_q && ctrl_q == '0));
  // R5
  srst_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && srst_q) |=> (ctrl_q == '0));
  // R5
  srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ($stable(srst_q) && $stable(ctrl_q)));
endmodule

// File: rtl/adc_cfg_sticky.sv
module adc_cfg_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb flag_d[i] = set[i] || (flag_q[i] && !clr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag_q[i]);
    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr) |=> flag_q[i]);
    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/adc_cfg_chop.sv
module adc_cfg_chop #(
  parameter int CODE_W = 2,
  parameter int DIV_W  = 8
) (
  input  logic [CODE_W-1:0] code,
  output logic [DIV_W-1:0]  div
);
  localparam int SH_W = $clog2(DIV_W);
  logic [SH_W-1:0] sh;

  always_comb begin
    unique case (code)
      2'b00:   sh = SH_W'(7);
      2'b01:   sh = SH_W'(3);
      2'b10:   sh = SH_W'(1);
      default: sh = SH_W'(5);
    endcase
    div = DIV_W'(1) << sh;
  end

  // R9
  div_onehot_chk: assert final ($onehot(div));
endmodule

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
  import adc_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [23:0] wdata,
  output logic [23:0] rdata,
  input  logic        osc_evt,
  input  logic        ovr_evt,
  output logic [1:0]  chop_sel,
  output logic [7:0]  chop_div,
  output logic        multi_setup,
  output logic        loop_en,
  output logic        read_wait,
  output logic [3:0]  depth_ptr,
  output logic        sleep_sel,
  output logic        pump_oe,
  output logic        pwr_save,
  output logic        low_pwr,
  output logic        sys_rst
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  ctrl_t              ctrl_q;
  logic               srst_q;
  logic               srst_done;
  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  adc_cfg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .ctrl_q    (ctrl_q),
    .srst_q    (srst_q),
    .srst_done (srst_done)
  );

  assign flag_set = {srst_done, osc_evt, ovr_evt};

  adc_cfg_sticky #(.N(N_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .set    (flag_set),
    .clr    (rd_en),
    .flag_q (flag_q)
  );

  adc_cfg_chop #(.CODE_W(CHOP_W), .DIV_W(8)) u_chop (
    .code (ctrl_q.chop),
    .div  (chop_div)
  );

  always_comb begin
    rdata                    = pack_ctrl(ctrl_q);
    rdata[B_SRST]            = srst_q;
    rdata[B_FLAG +: N_FLAGS] = flag_q;
  end

  assign chop_sel    = ctrl_q.chop;
  assign multi_setup = ctrl_q.multi;
  assign loop_en     = ctrl_q.loop;
  assign read_wait   = ctrl_q.rdwait;
  assign depth_ptr   = ctrl_q.depth;
  assign sleep_sel   = ctrl_q.sleep;
  assign pump_oe     = !ctrl_q.pump_dis;
  assign pwr_save    = ctrl_q.psave;
  assign low_pwr     = ctrl_q.lowp;
  assign sys_rst     = srst_q;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rdata & RSVD_MASK) == '0);
  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && srst_q && !wdata[B_SRST]) |=> (!sys_rst && rdata[6]));
endmodule

// File: tb/adc_cfg_reg_bench.sv
module adc_cfg_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, osc_evt = 1'b0, ovr_evt = 1'b0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic [1:0]  chop_sel;
  logic [7:0]  chop_div;
  logic        multi_setup, loop_en, read_wait, sleep_sel, pump_oe;
  logic        pwr_save, low_pwr, sys_rst;
  logic [3:0]  depth_ptr;

  int compared = 0, mismatched = 0;
  bit done = 0;

  localparam logic [23:0] WMASK = 24'h37FF00;

  logic [23:0] m_cfg;
  logic        m_rs, m_rv, m_od, m_of;

  always #2 clk = ~clk;

  adc_cfg_reg u_adc_cfg_reg (.*);

  function automatic logic [23:0] exp_rdata();
    return m_cfg | {16'b0, m_rs, m_rv, m_od, m_of, 4'b0};
  endfunction

  function automatic logic [7:0] exp_div(input logic [1:0] c);
    case (c)
      2'd0: return 8'd128;
      2'd1: return 8'd8;
      2'd2: return 8'd2;
      default: return 8'd32;
    endcase
  endfunction

  function automatic logic [22:0] exp_outs();
    return {m_cfg[21:20], exp_div(m_cfg[21:20]), m_cfg[18], m_cfg[17],
            m_cfg[16], m_cfg[15:12], m_cfg[11], !m_cfg[10], m_cfg[9],
            m_cfg[8], m_rs};
  endfunction

  function automatic logic [22:0] act_outs();
    return {chop_sel, chop_div, multi_setup, loop_en, read_wait, depth_ptr,
            sleep_sel, pump_oe, pwr_save, low_pwr, sys_rst};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic w, input logic r, input logic [23:0] d,
                            input logic o, input logic v);
    logic done_evt;
    done_evt = w && m_rs && !d[7];
    if (w) begin
      if (m_rs || d[7]) m_cfg = '0;
      else              m_cfg = d & WMASK;
      m_rs = d[7];
    end
    m_rv = done_evt || (m_rv && !r);
    m_od = o || (m_od && !r);
    m_of = v || (m_of && !r);
  endtask

  // one cycle: check outputs, drive, check rdata, clock, update model
  task automatic cyc(input string tag, input logic w, input logic r,
                     input logic [23:0] d, input logic o, input logic v);
    @(negedge clk);
    check({tag, " R3 R9 R10 outputs"}, {9'b0, act_outs()}, {9'b0, exp_outs()});
    wr_en = w; rd_en = r; wdata = d; osc_evt = o; ovr_evt = v;
    #1;
    check({tag, " R11 R2 rdata"}, {8'b0, rdata}, {8'b0, exp_rdata()});
    @(posedge clk);
    model_step(w, r, d, o, v);
  endtask

  task automatic idle();
    cyc("idle", 0, 0, 24'h0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [23:0] d;
    seed = 32'd1234;
    void'($urandom(seed));
    m_cfg = '0; m_rs = 0; m_rv = 0; m_od = 0; m_of = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rdata", {8'b0, rdata}, 32'h0);
    check("R1 chop_div", {24'b0, chop_div}, 32'd128);
    check("R1 pump_oe", {31'b0, pump_oe}, 32'd1);

    // R2 R3 all ones except reset bit
    cyc("R3 write", 1, 0, 24'hFFFF7F, 0, 0);
    idle();
    check("R2 R3 readback", {8'b0, rdata}, 32'h37FF00);
    check("R10 pump off", {31'b0, pump_oe}, 32'd0);

    // R4 enter software reset
    cyc("R4 enter", 1, 0, 24'h3FFF80, 0, 0);
    idle();
    check("R4 sys_rst", {8'b0, rdata}, 32'h000080);
    // R5 writes ignored while in reset
    cyc("R5 ignored", 1, 0, 24'hFFFFFF, 0, 0);
    idle();
    check("R5 held", {8'b0, rdata}, 32'h000080);
    // R6 leave reset with nonzero data; fields stay 0, done flag set
    cyc("R6 leave", 1, 0, 24'h37FF70, 0, 0);
    idle();
    check("R5 R6 after leave", {8'b0, rdata}, 32'h000040);
    cyc("R6 read", 0, 1, 24'h0, 0, 0);
    idle();
    check("R6 cleared", {8'b0, rdata}, 32'h0);

    // R7 events and write attempts on flags
    cyc("R7 osc", 0, 0, 24'h0, 1, 0);
    cyc("R7 ovr", 0, 0, 24'h0, 0, 1);
    idle();
    check("R7 both set", {8'b0, rdata}, 32'h000030);
    cyc("R7 write flags", 1, 0, 24'h000070, 0, 0);
    idle();
    check("R7 write no effect", {8'b0, rdata}, 32'h000030);
    // R8 read and event together
    cyc("R8 read+osc", 0, 1, 24'h0, 1, 0);
    idle();
    check("R8 event wins", {8'b0, rdata}, 32'h000020);

    // R9 chop codes
    for (int c = 0; c < 4; c++) begin
      cyc("R9 chop", 1, 0, {2'b0, 2'(c), 20'h0}, 0, 0);
      idle();
      check("R9 divisor", {24'b0, chop_div}, {24'b0, exp_div(2'(c))});
    end

    // random mix
    for (int i = 0; i < 3000; i++) begin
      d = 24'($urandom);
      d[7] = ($urandom % 8) == 0;
      cyc("rand", ($urandom % 3) == 0, ($urandom % 4) == 0, d,
          ($urandom % 10) == 0, ($urandom % 10) == 0);
    end
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule